// File: doc/BRIEF.md
# Two-Stage Pipelined Memory Accumulator

This block adds up a list of 32-bit words held in a word-addressed read-only image. A word-index counter moves to the next address on every enabled clock. The word at that address is captured in a staging register, and on the following enabled clock the staged word is added into a running total. Because the memory read and the addition sit in different stages, each clock period only has to cover one of the two delays. The sum comes out one clock later than in a machine that adds the raw memory output directly.

The image is a flat input bus, with word i in bits [32*i+31 : 32*i]. The counter is 30 bits wide. Only its low bits select a word, so reading wraps around the image. A `run` input pauses the whole pipeline. A synchronous reset clears the counter, the staging register and the total together, so the staging register holds no stale word after reset.

Top module: `mem_accum_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, `word_idx` and `total` become 0 after that edge, and the staging register is cleared as well.
- R2: After each rising edge with `rst` low and `run` high, `word_idx` equals its previous value plus 1.
- R3: After each rising edge with `rst` low and `run` high, `total` equals its previous value plus the word that was staged before that edge. The word read at index k is therefore first reflected in `total` two enabled edges after `word_idx` showed k.
- R4: The word read for index k is `mem_image[32*j +: 32]`, where j is k modulo DEPTH (the low log2(DEPTH) bits of the index). The default DEPTH is 16.
- R5: An edge with `run` low and `rst` low leaves `word_idx`, the staged word and `total` unchanged. Accumulation resumes on the next enabled edge as if the pause had not happened.
- R6: The total wraps modulo 2^32 with no saturation.
- R7: A reset in the middle of a run discards the staged word. After reset the first enabled edge adds 0, and the second adds the word at index 0.
- R8: A word is sampled at the edge where `word_idx` points at it. Changing that word in the image afterwards does not change the amount added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Pipeline enable; low holds every stage |
| mem_image | input | DEPTH*32 | Flat word image, word i at bits [32*i +: 32] |
| word_idx | output | 30 | Current word index (fetch address) |
| total | output | 32 | Running sum |

## Verification
`word_idx` changes one enabled edge after a stimulus. A word's contribution reaches `total` two enabled edges after the index pointed at it: one edge to stage the word and one to add it. The bench keeps a behavioural model that holds the staged word in a queue. The model advances on the same edges as the design, and the bench compares both outputs at the falling edge that follows. Paused edges, resets issued mid-run and image rewrites after a fetch are all applied between edges, so the two-edge latency is counted explicitly in every scenario.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Function codes understood by the accumulate-stage ALU.
    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_AND = 2'd2,
        ALU_OR  = 2'd3
    } alu_op_e;

endpackage

// File: rtl/word_counter.sv
module word_counter #(
    parameter int IDX_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [IDX_W-1:0] idx
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (en) begin
            st_d.idx = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign idx = st_q.idx;

    // R2
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> idx == $past(idx) + IDX_W'(1));

    // R5
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(idx));

    // R1
    idx_clear_chk: assert property (@(posedge clk)
        rst |=> idx == '0);

endmodule

// File: rtl/word_select.sv
module word_select #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH*WORD_W-1:0] image,
    input  logic [AW-1:0]           addr,
    output logic [WORD_W-1:0]       word
);

    logic [WORD_W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign words[g] = image[g*WORD_W +: WORD_W];
    end

    assign word = words[addr];

endmodule

// File: rtl/fetch_stage.sv
module fetch_stage #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] staged
);

    typedef struct packed {
        logic [WORD_W-1:0] data;
    } stage_state_t;

    stage_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (en) begin
            st_d.data = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign staged = st_q.data;

    // R8
    stage_capture_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> staged == $past(rd_word));

    // R5
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(staged));

    // R7
    stage_clear_chk: assert property (@(posedge clk)
        rst |=> staged == '0);

endmodule

// File: rtl/alu_unit.sv
module alu_unit
    import acc_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  alu_op_e           op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic [WORD_W-1:0] y
);

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/accum_stage.sv
module accum_stage
    import acc_pkg::*;
#(
    parameter int      WORD_W = 32,
    parameter alu_op_e OP     = ALU_ADD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] addend,
    output logic [WORD_W-1:0] total
);

    typedef struct packed {
        logic [WORD_W-1:0] sum;
    } acc_state_t;

    acc_state_t        st_d, st_q;
    logic [WORD_W-1:0] alu_y;

    alu_unit #(.WORD_W(WORD_W)) u_alu (
        .op (OP),
        .a  (st_q.sum),
        .b  (addend),
        .y  (alu_y)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (en) begin
            st_d.sum = alu_y;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign total = st_q.sum;

    // R3
    sum_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && OP == ALU_ADD) |=> total == $past(total) + $past(addend));

    // R5
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(total));

    // R1
    sum_clear_chk: assert property (@(posedge clk)
        rst |=> total == '0);

endmodule

// File: rtl/mem_accum_pipe.sv
module mem_accum_pipe
    import acc_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int IDX_W  = 30,
    parameter int DEPTH  = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic [DEPTH*WORD_W-1:0] mem_image,
    output logic [IDX_W-1:0]        word_idx,
    output logic [WORD_W-1:0]       total
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] staged;

    word_counter #(.IDX_W(IDX_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .en  (run),
        .idx (idx)
    );

    word_select #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_sel (
        .image (mem_image),
        .addr  (idx[AW-1:0]),
        .word  (rd_word)
    );

    fetch_stage #(.WORD_W(WORD_W)) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .en      (run),
        .rd_word (rd_word),
        .staged  (staged)
    );

    accum_stage #(.WORD_W(WORD_W), .OP(ALU_ADD)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .en     (run),
        .addend (staged),
        .total  (total)
    );

    assign word_idx = idx;

    initial begin
        assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
            else $error("DEPTH must be a power of two");
    end

endmodule

// File: tb/tb_mem_accum_pipe.sv
module tb_mem_accum_pipe;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 32;
    localparam int IDX_W      = 30;
    localparam int DEPTH      = 16;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    run = 1'b0;
    logic [DEPTH*WORD_W-1:0] mem_image = '0;
    logic [IDX_W-1:0]        word_idx;
    logic [WORD_W-1:0]       total;

    int    n_checks = 0;
    int    n_fail   = 0;
    string sum_tag  = "R3";

    // Behavioural reference state
    longint      m_idx = 0;
    logic [31:0] m_total = '0;
    logic [31:0] m_pipe[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_accum_pipe #(.WORD_W(WORD_W), .IDX_W(IDX_W), .DEPTH(DEPTH)) dut (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .mem_image (mem_image),
        .word_idx  (word_idx),
        .total     (total)
    );

    function automatic logic [31:0] img_word(int i);
        return mem_image[i*WORD_W +: WORD_W];
    endfunction

    task automatic set_word(int i, logic [31:0] v);
        mem_image[i*WORD_W +: WORD_W] = v;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One clock: advance model at the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_idx   = 0;
            m_total = '0;
            m_pipe  = {32'h0};
        end else if (run) begin
            m_total = m_total + m_pipe.pop_front();
            m_pipe.push_back(img_word(int'(m_idx % DEPTH)));
            m_idx   = m_idx + 1;
        end
        @(negedge clk);
        check("R2", 32'(word_idx), 32'(m_idx));
        check(sum_tag, total, m_total);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        logic [31:0] sum16;
        m_pipe = {32'h0};
        for (int i = 0; i < DEPTH; i++) set_word(i, 32'(i + 1));

        // R1: reset state
        rst = 1'b1; run = 1'b1;
        step(); step();
        check("R1", total, 32'h0);
        check("R1", 32'(word_idx), 32'h0);

        // R3/R4: ascending pattern; sum 1..16 = 136 after 17 enabled edges
        rst = 1'b0;
        step();
        check("R7", total, 32'h0);   // first edge adds cleared stage
        step();
        check("R4", total, 32'h1);   // word at index 0
        for (int c = 0; c < 15; c++) step();
        check("R3", total, 32'd136);
        // R4: wrap of the image by low index bits
        for (int c = 0; c < DEPTH; c++) step();
        check("R4", total, 32'd272);

        // R5: pause, then resume
        sum_tag = "R5";
        snap = total;
        run = 1'b0;
        for (int c = 0; c < 4; c++) step();
        check("R5", total, snap);
        run = 1'b1;
        for (int c = 0; c < 6; c++) begin
            step();
            run = (c % 2 == 0) ? 1'b0 : 1'b1;
        end
        run = 1'b1;
        step();

        // R7: mid-run reset discards staged word
        sum_tag = "R7";
        rst = 1'b1;
        step();
        rst = 1'b0;
        step();
        check("R7", total, 32'h0);
        step();
        check("R7", total, img_word(0));

        // R6: large values wrap modulo 2^32
        sum_tag = "R6";
        for (int i = 0; i < DEPTH; i++) set_word(i, 32'hF000_0000 + 32'(i * 7919));
        rst = 1'b1; step(); rst = 1'b0;
        for (int c = 0; c < DEPTH + 1; c++) step();
        sum16 = '0;
        for (int i = 0; i < DEPTH; i++) sum16 = sum16 + img_word(i);
        check("R6", total, sum16);

        // R8: rewrite a word after it has been fetched
        sum_tag = "R8";
        rst = 1'b1; step(); rst = 1'b0;
        for (int i = 0; i < DEPTH; i++) set_word(i, 32'h0000_0100 * 32'(i + 1));
        step();                      // index 0 staged
        set_word(0, 32'hDEAD_0000);  // too late to matter
        step();
        check("R8", total, 32'h0000_0100);
        set_word(1, 32'hBEEF_0000);  // index 1 already staged
        step();
        check("R8", total, 32'h0000_0300);
        for (int c = 0; c < 20; c++) step();

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule